// File: doc/BRIEF.md
# DRAM Power-Up Command Sequencer

This block walks a DDR1 or DDR2 memory through its power-up command script after reset. A strap input, captured at the rising edge of `start`, picks one of two scripts. Each step of the script raises exactly one bit of a command strobe vector for a single cycle. Precharge-all, auto refresh and the four mode register updates each have their own bit. The mode or extended-mode value that belongs to a step is loaded onto its output in the same cycle as the strobe. A fixed, parameterized wait separates every step from the one before it.

After the last command and one more wait, the block publishes the refresh control word and the per-mode default for both DQS tap settings. It then raises `done` and keeps it high until the next reset. The physical timing of the DRAM pins and the data path belong to other blocks. This block only produces the ordered commands and the values that go with them.

Top module: `dram_init_seq`

## Requirements
- R1: While reset is asserted and after it is released, before any start, `cmd_strobe`, `mode_val`, `ext_val`, `refresh_ctl`, both tap outputs and `done` are all zero.
- R2: `cmd_strobe` is one-hot when active, with bit 0 = mode register update, bit 1 = extended mode update, bit 2 = auto refresh, bit 3 = precharge-all, bit 4 = EMR2 update, bit 5 = EMR3 update. No more than one bit is high in any cycle, and each pulse lasts one cycle.
- R3: The first strobe appears WAIT_CYCLES clock edges after the edge that sees `start` rise. Each later strobe appears exactly WAIT_CYCLES edges after the one before it.
- R4: With `strap_ddr1`=1 the strobes are, in order: precharge-all, EMRS with value 0x000, MRS with 0x133, precharge-all, auto refresh, auto refresh, MRS with 0x033.
- R5: With `strap_ddr1`=0 the strobes are, in order: EMR2, EMR3, precharge-all, EMR2, EMR3, EMRS 0x402, MRS 0x143, precharge-all, auto refresh, auto refresh, MRS 0x043, EMRS 0x782, EMRS 0x402.
- R6: `mode_val` changes only in the cycle of a bit-0 strobe and `ext_val` only in the cycle of a bit-1 strobe. In that cycle each shows its step's value.
- R7: `done` rises WAIT_CYCLES edges after the last strobe and stays high until reset. In the same cycle `refresh_ctl` becomes 0x4138 (bit 14 enable, bits 9:0 interval 312). No strobe follows.
- R8: The strap is sampled only when `start` rises. Changing it during the sequence does not alter the script.
- R9: A `start` held high starts only one sequence. A new rising edge of `start` after `done` starts nothing.
- R10: When `done` rises, `dqs_tap0` and `dqs_tap1` both read 0x20 in DDR1 mode and 0x10 in DDR2 mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Rising edge starts the script |
| strap_ddr1 | input | 1 | 1 selects the DDR1 script, 0 selects DDR2 |
| cmd_strobe | output | 6 | One-cycle command pulses, one-hot |
| mode_val | output | MR_W | Mode register value of the latest MRS step |
| ext_val | output | MR_W | Extended mode value of the latest EMRS step |
| refresh_ctl | output | 15 | Refresh enable (bit 14) and interval (bits 9:0) |
| dqs_tap0 | output | TAP_W | DQS lane 0 tap default |
| dqs_tap1 | output | TAP_W | DQS lane 1 tap default |
| done | output | 1 | Sequence finished; sticky until reset |

## Verification
Every cycle, the assertions check four properties: the strobe vector is one-hot, each pulse lasts one cycle, the spacing between pulses is exact, and the value outputs move only with their own strobe. They also check that `done` is sticky and silences the strobes. Only the bench scenarios can show the order of the two scripts with their values, the cycle at which `done` appears, the refresh word and tap defaults, and that a strap change mid-run or a late start leaves the trace untouched.

// File: rtl/dram_init_seq.sv
module dram_init_seq #(
  parameter int WAIT_CYCLES  = 8,
  parameter int MR_W         = 13,
  parameter int REF_INTERVAL = 312,
  parameter int TAP_W        = 7,
  parameter int TAP_DDR1     = 32,
  parameter int TAP_DDR2     = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             strap_ddr1,
  output logic [5:0]       cmd_strobe,
  output logic [MR_W-1:0]  mode_val,
  output logic [MR_W-1:0]  ext_val,
  output logic [14:0]      refresh_ctl,
  output logic [TAP_W-1:0] dqs_tap0,
  output logic [TAP_W-1:0] dqs_tap1,
  output logic             done
);
  localparam int CNT_W  = $clog2(WAIT_CYCLES + 1);
  localparam int IDX_W  = 4;
  localparam int N_DDR1 = 7;
  localparam int N_DDR2 = 13;
  localparam logic [5:0] C_MRS = 6'b000001;
  localparam logic [5:0] C_EMR = 6'b000010;
  localparam logic [5:0] C_ARF = 6'b000100;
  localparam logic [5:0] C_PRE = 6'b001000;
  localparam logic [5:0] C_EM2 = 6'b010000;
  localparam logic [5:0] C_EM3 = 6'b100000;

  function automatic logic [18:0] script(input logic d1, input logic [IDX_W-1:0] i);
    if (d1) begin
      case (i)
        4'd0:    return {C_PRE, 13'h000};
        4'd1:    return {C_EMR, 13'h000};
        4'd2:    return {C_MRS, 13'h133};
        4'd3:    return {C_PRE, 13'h000};
        4'd4:    return {C_ARF, 13'h000};
        4'd5:    return {C_ARF, 13'h000};
        4'd6:    return {C_MRS, 13'h033};
        default: return '0;
      endcase
    end else begin
      case (i)
        4'd0:    return {C_EM2, 13'h000};
        4'd1:    return {C_EM3, 13'h000};
        4'd2:    return {C_PRE, 13'h000};
        4'd3:    return {C_EM2, 13'h000};
        4'd4:    return {C_EM3, 13'h000};
        4'd5:    return {C_EMR, 13'h402};
        4'd6:    return {C_MRS, 13'h143};
        4'd7:    return {C_PRE, 13'h000};
        4'd8:    return {C_ARF, 13'h000};
        4'd9:    return {C_ARF, 13'h000};
        4'd10:   return {C_MRS, 13'h043};
        4'd11:   return {C_EMR, 13'h782};
        4'd12:   return {C_EMR, 13'h402};
        default: return '0;
      endcase
    end
  endfunction

  typedef enum logic [1:0] {IDLE, RUN, FIN} st_t;

  st_t              st;
  logic             start_q, mode1;
  logic [CNT_W-1:0] wait_cnt;
  logic [IDX_W-1:0] idx;
  logic [18:0]      step;

  assign step = script(mode1, idx);

  wire launch = (st == IDLE) && start && !start_q;
  wire fire   = (st == RUN) && (wait_cnt == '0);
  wire last   = idx == (mode1 ? IDX_W'(N_DDR1) : IDX_W'(N_DDR2));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= IDLE;
      start_q     <= 1'b0;
      mode1       <= 1'b0;
      wait_cnt    <= '0;
      idx         <= '0;
      cmd_strobe  <= '0;
      mode_val    <= '0;
      ext_val     <= '0;
      refresh_ctl <= '0;
      dqs_tap0    <= '0;
      dqs_tap1    <= '0;
      done        <= 1'b0;
    end else begin
      start_q    <= start;
      cmd_strobe <= '0;
      if (launch) begin
        mode1    <= strap_ddr1;
        idx      <= '0;
        wait_cnt <= CNT_W'(WAIT_CYCLES - 1);
        st       <= RUN;
      end else if (fire) begin
        if (last) begin
          st          <= FIN;
          done        <= 1'b1;
          refresh_ctl <= {1'b1, 4'b0000, 10'(REF_INTERVAL)};
          dqs_tap0    <= mode1 ? TAP_W'(TAP_DDR1) : TAP_W'(TAP_DDR2);
          dqs_tap1    <= mode1 ? TAP_W'(TAP_DDR1) : TAP_W'(TAP_DDR2);
        end else begin
          cmd_strobe <= step[18:13];
          if (step[18:13] == C_MRS) mode_val <= MR_W'(step[12:0]);
          if (step[18:13] == C_EMR) ext_val  <= MR_W'(step[12:0]);
          idx      <= idx + 1'b1;
          wait_cnt <= CNT_W'(WAIT_CYCLES - 1);
        end
      end else if (st == RUN) begin
        wait_cnt <= wait_cnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/dram_init_seq_chk.sv
module dram_init_seq_chk #(
  parameter int WAIT_CYCLES = 8,
  parameter int MR_W        = 13
) (
  input logic            clk,
  input logic            rst_n,
  input logic [5:0]      cmd_strobe,
  input logic [MR_W-1:0] mode_val,
  input logic [MR_W-1:0] ext_val,
  input logic            done
);
  logic [15:0] gap;
  logic        seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap  <= '0;
      seen <= 1'b0;
    end else if (|cmd_strobe) begin
      gap  <= 16'd1;
      seen <= 1'b1;
    end else if (gap != 16'hffff) begin
      gap <= gap + 16'd1;
    end
  end

  // R2
  onehot_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cmd_strobe));

  // R2
  single_cycle_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|cmd_strobe) |=> (cmd_strobe == '0));

  // R3
  step_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|cmd_strobe) && seen) |-> (gap == 16'(WAIT_CYCLES)));

  // R6
  mode_val_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mode_val) |-> cmd_strobe[0]);

  // R6
  ext_val_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ext_val) |-> cmd_strobe[1]);

  // R7
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);

  // R7
  quiet_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cmd_strobe == '0));
endmodule

bind dram_init_seq dram_init_seq_chk #(.WAIT_CYCLES(WAIT_CYCLES), .MR_W(MR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_strobe(cmd_strobe),
  .mode_val(mode_val), .ext_val(ext_val), .done(done)
);

// File: tb/tb_dram_init_seq.sv
module tb_dram_init_seq;
  localparam int W = 8;
  localparam logic [5:0] MRS = 6'h01, EMR = 6'h02, ARF = 6'h04, PRE = 6'h08, EM2 = 6'h10, EM3 = 6'h20;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, strap = 1'b0;
  logic [5:0]  cmd_strobe;
  logic [12:0] mode_val, ext_val;
  logic [14:0] refresh_ctl;
  logic [6:0]  dqs_tap0, dqs_tap1;
  logic        done;

  always #5 clk = ~clk;

  dram_init_seq #(.WAIT_CYCLES(W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .strap_ddr1(strap),
    .cmd_strobe(cmd_strobe), .mode_val(mode_val), .ext_val(ext_val),
    .refresh_ctl(refresh_ctl), .dqs_tap0(dqs_tap0), .dqs_tap1(dqs_tap1), .done(done)
  );

  typedef struct packed { logic [5:0] cmd; logic [12:0] val; } item_t;
  item_t q[$];
  int tests = 0, fails = 0, edges = 0, last_edge = 0;
  string cur_req = "R4";
  bit finished = 0;

  always @(posedge clk) edges++;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(logic [5:0] c, logic [12:0] v);
    q.push_back({c, v});
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    item_t e;
    if (rst_n && cmd_strobe != 6'h00) begin
      chk("R2 one-hot", $countones(cmd_strobe), 1);
      if (q.size() == 0) begin
        tests++; fails++;
        $display("FAIL R9 unexpected strobe actual=%0h expected=0", cmd_strobe);
      end else begin
        e = q.pop_front();
        chk(cur_req, cmd_strobe, e.cmd);
        if (e.cmd == MRS) chk("R6 mode_val", mode_val, e.val);
        if (e.cmd == EMR) chk("R6 ext_val", ext_val, e.val);
        chk("R3 spacing", edges - last_edge, W);
        last_edge = edges;
      end
    end
  end

  task automatic run_mode(bit d1);
    rst_n = 1'b0; start = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 strobe", cmd_strobe, 0);
    chk("R1 done", done, 0);
    chk("R1 refresh", refresh_ctl, 0);
    chk("R1 taps", {dqs_tap0, dqs_tap1}, 0);
    chk("R1 values", {mode_val, ext_val}, 0);
    if (d1) begin
      cur_req = "R4";
      push(PRE, 0); push(EMR, 13'h000); push(MRS, 13'h133); push(PRE, 0);
      push(ARF, 0); push(ARF, 0); push(MRS, 13'h033);
    end else begin
      cur_req = "R5";
      push(EM2, 0); push(EM3, 0); push(PRE, 0); push(EM2, 0); push(EM3, 0);
      push(EMR, 13'h402); push(MRS, 13'h143); push(PRE, 0); push(ARF, 0);
      push(ARF, 0); push(MRS, 13'h043); push(EMR, 13'h782); push(EMR, 13'h402);
    end
    strap = d1;
    @(posedge clk);
    #1 start = 1'b1;
    last_edge = edges + 1;
    // R9: start held high for several cycles
    repeat (3) @(posedge clk);
    #1 start = 1'b0;
    // R8: strap flips mid-sequence, script must not change
    strap = ~d1;
    while (!done) @(negedge clk);
    chk("R7 done timing", edges - last_edge, W);
    chk("R7 script consumed", q.size(), 0);
    chk("R7 refresh word", refresh_ctl, 15'h4138);
    chk("R10 tap0", dqs_tap0, d1 ? 7'h20 : 7'h10);
    chk("R10 tap1", dqs_tap1, d1 ? 7'h20 : 7'h10);
    // R9: new start after done triggers nothing
    @(posedge clk);
    #1 start = 1'b1;
    repeat (3 * W) @(negedge clk);
    chk("R9 done held", done, 1);
    chk("R9 no strobe", cmd_strobe, 0);
    start = 1'b0;
  endtask

  initial begin
    run_mode(1'b1);
    run_mode(1'b0);
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      tests++; fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule